// File: doc/BRIEF.md
# ADC sample packet sequencer

This block is the serial-side controller for an isolated ADC slave. Command bytes come in through a byte-wide receive port that carries a data byte and a one-cycle valid strobe, as a UART receiver would produce. Each command byte is a complete image of an 8-bit configuration register. The block stores the byte, asks the converter for a sample through a start/done handshake, and sends a three-byte result packet out of a byte-wide transmit port with ready/valid flow control.

Bit 0 of the configuration selects how conversions are triggered. When it is 1 (on-demand), every command produces exactly one conversion and one packet. When it is 0 (continuous), the block starts the next conversion as soon as the previous packet has left, with no further commands. Each packet first echoes the configuration byte, so a master can verify which settings produced the sample. The two data bytes that follow can be read only through such a packet.

Top module: `adc_pkt_seq`

## Requirements
- R1: After reset the configuration holds the on-demand value (bit 0 = 1). Until a command byte arrives, conv_start and tx_valid stay low.
- R2: With bit 0 = 1, each command byte produces exactly one conv_start pulse and exactly one three-byte packet, after which the block is idle.
- R3: A command byte replaces all 8 configuration bits. Byte 0 of every packet equals the full configuration byte in force for that conversion.
- R4: Packet bytes leave in a fixed order. Byte 0 is the configuration, byte 1 is result bits [15:8], and byte 2 is result bits [7:0]. Byte-1 bits above a result narrower than 16 bits are zero.
- R5: With bit 0 = 0, the next conversion starts after each packet without any command, and every conversion yields one packet.
- R6: A command that arrives during a conversion or a packet is held. The packet in flight completes unchanged, and then the new configuration is applied and a conversion is started. conv_start is never high while tx_valid is high.
- R7: A command with bit 0 = 1 received in continuous mode ends free-running operation. The packet in progress completes, exactly one conversion follows for the new command, and then the block idles.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.
- R9: conv_start is a single-cycle pulse. It is not asserted again until conv_done has returned for the previous start.
- R10: conv_done with no conversion outstanding is ignored and produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_data valid |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_done | input | 1 | Converter reports a finished sample |
| conv_result | input | RES_W | Sample value, valid with conv_done |
| tx_data | output | 8 | Packet byte to transmit |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |

## Verification
The bench builds the block with RES_W = 12. This lets it check that the top four bits of every high byte are zero, while the low byte and the rest of the high byte carry sample data. It sweeps all 128 on-demand command values (every byte with bit 0 set) across three tx_ready stall patterns and converter latencies of 0 to 3 cycles, and computes every expected sample arithmetically from the conversion index. Further phases cover a command landing during a conversion, a continuous run cut short by an on-demand command in the middle of a packet, and a stray conv_done while the block is idle.

// File: rtl/adc_seq_pkg.sv
// Shared constants and types for the ADC sample packet sequencer.
// Assumes an 8-bit serial byte and a fixed three-byte packet.
package adc_seq_pkg;
    localparam int BYTE_W     = 8;
    localparam int DATA_BYTES = 2;
    localparam int PKT_LEN    = DATA_BYTES + 1;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_START = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_SEND  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cmd_cfg_store.sv
// Command capture and configuration register.
// Holds the most recent unapplied command byte in a one-entry slot; a newer
// byte overwrites an older unapplied one. The sequencer copies the slot into
// the configuration register by pulsing apply. Assumes rx_valid is a strobe.
module cmd_cfg_store
    import adc_seq_pkg::*;
#(
    parameter int                MODE_BIT  = 0,
    parameter logic [BYTE_W-1:0] RESET_CFG = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              apply,
    output logic [BYTE_W-1:0] cfg,
    output logic              cont_mode,
    output logic              pend_valid
);
    logic [BYTE_W-1:0] slot_q;
    logic              slot_vld_q;
    logic [BYTE_W-1:0] cfg_q;

    // Capture a received byte; a same-cycle apply still leaves the new byte pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            slot_vld_q <= 1'b0;
        end else if (rx_valid) begin
            slot_q     <= rx_data;
            slot_vld_q <= 1'b1;
        end else if (apply) begin
            slot_vld_q <= 1'b0;
        end
    end

    // Replace the whole configuration with the pending command on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RESET_CFG;
        end else if (apply) begin
            cfg_q <= slot_q;
        end
    end

    assign cfg        = cfg_q;
    assign cont_mode  = ~cfg_q[MODE_BIT];
    assign pend_valid = slot_vld_q;
endmodule

// File: rtl/seq_fsm.sv
// Conversion sequencer.
// Idle until a command is pending, then: apply it, pulse a conversion start,
// wait for the converter, hand the sample to the packet serializer and wait
// for the last byte. At packet end a pending command takes priority; otherwise
// continuous mode loops straight into the next conversion.
module seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_valid,
    input  logic cont_mode,
    input  logic conv_done,
    input  logic pkt_done,
    output logic apply,
    output logic conv_start,
    output logic load
);
    seq_state_t state_q, state_d;

    // Next-state and control decode.
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (pend_valid) begin
                    apply   = 1'b1;
                    state_d = SQ_START;
                end
            end
            SQ_START: begin
                state_d = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    load    = 1'b1;
                    state_d = SQ_SEND;
                end
            end
            SQ_SEND: begin
                if (pkt_done) begin
                    if (pend_valid) begin
                        apply   = 1'b1;
                        state_d = SQ_START;
                    end else if (cont_mode) begin
                        state_d = SQ_START;
                    end else begin
                        state_d = SQ_IDLE;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    assign conv_start = (state_q == SQ_START);
endmodule

// File: rtl/pkt_serializer.sv
// Result packet serializer.
// On load it snapshots the configuration byte and the sample, zero-extended
// to the data field, into a packet image. It then presents the bytes in order
// with ready/valid and pulses pkt_done on the cycle the last byte is accepted.
// Assumes load only arrives while no packet is in flight.
module pkt_serializer
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] cfg_byte,
    input  logic [RES_W-1:0]  result,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              pkt_done
);
    localparam int                IDX_W    = $clog2(PKT_LEN);
    localparam int                RES_SPAN = DATA_BYTES * BYTE_W;
    localparam logic [IDX_W-1:0]  LAST     = IDX_W'(PKT_LEN - 1);

    logic [RES_SPAN-1:0] res_ext;
    logic [BYTE_W-1:0]   img     [PKT_LEN];
    logic [BYTE_W-1:0]   pkt_q   [PKT_LEN];
    logic [IDX_W-1:0]    idx_q;
    logic                busy_q;

    // Fit the sample into the data field, padding unused upper bits with zero.
    generate
        if (RES_W < RES_SPAN) begin : g_pad
            assign res_ext = {{(RES_SPAN - RES_W){1'b0}}, result};
        end else begin : g_full
            assign res_ext = result[RES_SPAN-1:0];
        end
    endgenerate

    // Packet image: configuration echo first, then data bytes most significant first.
    assign img[0] = cfg_byte;
    generate
        for (genvar j = 1; j < PKT_LEN; j++) begin : g_img
            assign img[j] = res_ext[(PKT_LEN - 1 - j) * BYTE_W +: BYTE_W];
        end
    endgenerate

    // Snapshot the packet image when a sample is handed over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PKT_LEN; i++) pkt_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < PKT_LEN; i++) pkt_q[i] <= img[i];
        end
    end

    // Byte pointer and busy flag; advance only on an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && tx_ready) begin
            if (idx_q == LAST) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    assign tx_data  = pkt_q[idx_q];
    assign tx_valid = busy_q;
    assign pkt_done = busy_q && tx_ready && (idx_q == LAST);
endmodule

// File: rtl/adc_pkt_seq.sv
// ADC sample packet sequencer, top level.
// Joins command capture, the conversion sequencer and the packet serializer.
// Assumes the converter holds conv_result valid while conv_done is high and
// returns exactly one conv_done per conv_start. RES_W is expected to be 9..16.
module adc_pkt_seq
    import adc_seq_pkg::*;
#(
    parameter int                RES_W     = 16,
    parameter int                MODE_BIT  = 0,
    parameter logic [BYTE_W-1:0] RESET_CFG = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready
);
    logic [BYTE_W-1:0] cfg_cur;
    logic              cont_mode;
    logic              pend_vld;
    logic              apply;
    logic              load;
    logic              pkt_done;

    cmd_cfg_store #(
        .MODE_BIT  (MODE_BIT),
        .RESET_CFG (RESET_CFG)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .apply      (apply),
        .cfg        (cfg_cur),
        .cont_mode  (cont_mode),
        .pend_valid (pend_vld)
    );

    seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_valid (pend_vld),
        .cont_mode  (cont_mode),
        .conv_done  (conv_done),
        .pkt_done   (pkt_done),
        .apply      (apply),
        .conv_start (conv_start),
        .load       (load)
    );

    pkt_serializer #(
        .RES_W (RES_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_byte (cfg_cur),
        .result   (conv_result),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .pkt_done (pkt_done)
    );
endmodule

// File: rtl/adc_pkt_seq_chk.sv
// Protocol checker for adc_pkt_seq, attached by bind.
// Tracks outstanding conversions and packet byte position on its own.
module adc_pkt_seq_chk #(
    parameter int RES_W = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_start,
    input logic       conv_done,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] cfg_cur,
    input logic       cont_mode,
    input logic       pend_vld,
    input logic       pkt_done
);
    localparam int         HI_BITS = (RES_W > 8) ? RES_W - 8 : 0;
    localparam logic [7:0] HI_MASK = 8'hFF << HI_BITS;

    logic       outstanding;
    logic [1:0] pos;

    // Record whether a conversion is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (conv_start) outstanding <= 1'b1;
        else if (conv_done)  outstanding <= 1'b0;
    end

    // Byte position within the current packet, from the handshake alone.
    always_ff @(posedge clk) begin
        if (!rst_n) pos <= 2'd0;
        else if (tx_valid && tx_ready) pos <= (pos == 2'd2) ? 2'd0 : pos + 2'd1;
    end

    // R9
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9
    conv_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !outstanding);

    // R6
    no_conv_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !tx_valid);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10
    tx_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(conv_done));

    // R3
    echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && pos == 2'd0) |-> (tx_data == cfg_cur));

    // R5
    cont_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && cont_mode && !pend_vld) |=> conv_start);

    generate
        if (HI_BITS < 8) begin : g_pad_chk
            // R4
            hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid && pos == 2'd1) |-> ((tx_data & HI_MASK) == 8'h00));
        end
    endgenerate
endmodule

bind adc_pkt_seq adc_pkt_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .cfg_cur    (cfg_cur),
    .cont_mode  (cont_mode),
    .pend_vld   (pend_vld),
    .pkt_done   (pkt_done)
);

// File: tb/sim_adc_pkt_seq.sv
`timescale 1ns/1ps
// Bench for adc_pkt_seq built with a 12-bit result.
module sim_adc_pkt_seq;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          conv_start;
    logic          conv_done;
    logic [RW-1:0] conv_result;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_ready;

    always #2.5 clk = ~clk;

    adc_pkt_seq #(.RES_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;
    logic [7:0] got [0:4095];
    int         nbytes = 0;
    int         starts = 0;
    int         bad_start = 0;
    int         rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit         spur_req = 0;
    bit         adc_busy = 0;
    int         adc_cnt = 0;
    int         adc_k = 0;
    bit         hold_prev = 0;
    logic [7:0] prev_data = 8'h00;

    function automatic int exp_res(int k);
        return (k * 2531 + 291) & ((1 << RW) - 1);
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic send_cmd(logic [7:0] b);
        @(posedge clk); #1;
        rx_data  = b;
        rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic wait_bytes(int n);
        while (nbytes < n) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare packet p against its configuration echo and computed sample.
    task automatic check_pkt(int p, logic [7:0] cfg, string req);
        int r = exp_res(p);
        check_eq({req, " R3 echo"}, int'(got[3*p]), int'(cfg));
        check_eq({req, " R4 high"}, int'(got[3*p+1]), (r >> 8) & 8'hFF);
        check_eq({req, " R4 low"},  int'(got[3*p+2]), r & 8'hFF);
    endtask

    // Converter model: 0..3 cycle latency, one sample per start, optional stray done.
    initial begin
        conv_done   = 1'b0;
        conv_result = '0;
        forever begin
            @(posedge clk); #1;
            conv_done = 1'b0;
            if (adc_busy) begin
                if (adc_cnt == 0) begin
                    conv_done   = 1'b1;
                    conv_result = RW'(exp_res(adc_k));
                    adc_k++;
                    adc_busy = 0;
                end else begin
                    adc_cnt--;
                end
            end else if (spur_req) begin
                conv_done   = 1'b1;
                conv_result = RW'(12'hABC);
                spur_req    = 0;
            end
            if (rst_n && conv_start) begin
                if (adc_busy) bad_start++;
                starts++;
                adc_busy = 1;
                adc_cnt  = starts % 4;
            end
        end
    end

    // Downstream ready: always, about half, or about a quarter of cycles.
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       tx_ready = 1'b1;
                1:       tx_ready = lfsr[0];
                default: tx_ready = lfsr[0] & lfsr[3];
            endcase
        end
    end

    // Byte collector and hold check (R8).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hold_prev) begin
                    check_eq("R8 valid held", int'(tx_valid), 1);
                    check_eq("R8 data held", int'(tx_data), int'(prev_data));
                end
                if (tx_valid && tx_ready) begin
                    got[nbytes] = tx_data;
                    nbytes++;
                end
                hold_prev = tx_valid && !tx_ready;
                prev_data = tx_data;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        int p;
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        rx_data  = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: no activity without a command.
        idle(20);
        check_eq("R1 no bytes", nbytes, 0);
        check_eq("R1 no starts", starts, 0);
        check_eq("R1 tx_valid", int'(tx_valid), 0);

        // R10: stray conv_done while idle.
        spur_req = 1;
        idle(10);
        check_eq("R10 stray done no bytes", nbytes, 0);
        check_eq("R10 stray done no starts", starts, 0);

        // R2/R3/R4: every on-demand command value, three ready patterns.
        p = 0;
        for (int c = 0; c < 128; c++) begin
            logic [7:0] cmd;
            cmd = 8'((c << 1) | 1);
            rdy_mode = c % 3;
            send_cmd(cmd);
            wait_bytes(3 * (p + 1));
            idle(8);
            check_pkt(p, cmd, "sweep");
            check_eq("R2 one conversion", starts, p + 1);
            check_eq("R2 one packet", nbytes, 3 * (p + 1));
            p++;
        end

        // R6: second command lands while the first conversion is running.
        rdy_mode = 1;
        send_cmd(8'h03);
        while (starts < p + 1) @(negedge clk);
        send_cmd(8'h05);
        wait_bytes(3 * (p + 2));
        idle(10);
        check_pkt(p, 8'h03, "R6 first");
        check_pkt(p + 1, 8'h05, "R6 held");
        check_eq("R6 conversions", starts, p + 2);
        check_eq("R6 bytes", nbytes, 3 * (p + 2));
        p += 2;

        // R5/R7: continuous run, then on-demand command in the middle of packet 7.
        rdy_mode = 2;
        send_cmd(8'hC4);
        wait_bytes(3 * (p + 6) + 1);
        send_cmd(8'h81);
        wait_bytes(3 * (p + 8));
        idle(30);
        for (int q = 0; q < 7; q++) check_pkt(p + q, 8'hC4, "R5 continuous");
        check_pkt(p + 7, 8'h81, "R7 switch");
        check_eq("R7 stopped bytes", nbytes, 3 * (p + 8));
        check_eq("R5 one start per packet", starts, p + 8);
        p += 8;

        // R5: continuous with free ready, then stopped by an on-demand command.
        rdy_mode = 0;
        send_cmd(8'h7E);
        wait_bytes(3 * (p + 3) + 1);
        send_cmd(8'h01);
        wait_bytes(3 * (p + 5));
        idle(30);
        for (int q = 0; q < 4; q++) check_pkt(p + q, 8'h7E, "R5 free ready");
        check_pkt(p + 4, 8'h01, "R7 free ready");
        check_eq("R7 stopped free", nbytes, 3 * (p + 5));

        check_eq("R9 start while busy", bad_start, 0);
        report();
    end
endmodule